// File: doc/BRIEF.md
# Synchronous serial frame word formatter

This block assembles the parallel word that a synchronous serial transmitter shifts out MSB first. It takes a signed main measurement, an optional 8-bit auxiliary value, an error flag and a set of configuration inputs. From these it builds a left-aligned frame word and reports the number of valid bits. The configuration chooses the main field length, binary or Gray coding, and two's complement or sign-magnitude output. It also enables a parity bit with even or odd sense, an error-indicator bit and the auxiliary field.

The parity bit and the error bit are placed inside the configured main length rather than added to it, so each one enabled costs one data bit. When Gray coding is on, the main data bits and the auxiliary byte are coded separately. The word and its length are captured on a single-cycle latch strobe. Both then stay frozen until the next strobe, so the shifter always sends a consistent snapshot.

Top module: `ssi_frame_fmt`

## Requirements
- R1: The main length N is 24 when `len_sel_i` is 0, 25 when it is 1, and 26 when it is 2 or 3. `frame_len_o` equals N, plus 8 when `add_en_i` is set.
- R2: The main field occupies the top N bits of `frame_o`, `frame_o[33]` downwards. Every bit below position 34 minus `frame_len_o` is zero.
- R3: The main field holds D data bits in its lowest positions, where D is N minus one for each enabled parity or error bit. In two's complement mode (`sign_mag_i`=0) these bits are the low D bits of `main_val_i`.
- R4: In sign-magnitude mode (`sign_mag_i`=1), the top data bit is the sign of `main_val_i`. The D-1 bits below it are the low bits of its absolute value.
- R5: With `gray_en_i`=1, the D data bits are sent as g = b XOR (b >> 1), computed over those D bits alone.
- R6: With `add_en_i`=1, the 8-bit auxiliary value follows directly below the main field. It is Gray-coded on its own when `gray_en_i`=1.
- R7: With `par_en_i`=1, the parity bit is `frame_o[33]`. The count of ones in the whole word is even when `par_odd_i`=0 and odd when `par_odd_i`=1.
- R8: With `err_bit_en_i`=1, the error bit sits directly below the parity bit, or at `frame_o[33]` when parity is off. It equals `err_flag_i`.
- R9: While `err_flag_i`=1, the D data bits are the low D bits of `err_val_i`, uncoded, whatever the coding and sign mode.
- R10: After reset `frame_o` and `frame_len_o` are zero. They change only in the cycle after `latch_i` is high and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| latch_i | input | 1 | Capture strobe for a new frame |
| len_sel_i | input | 2 | Main length select |
| gray_en_i | input | 1 | Gray coding enable |
| sign_mag_i | input | 1 | Sign-magnitude mode for negative values |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| err_bit_en_i | input | 1 | Error indicator bit enable |
| add_en_i | input | 1 | Auxiliary field enable |
| main_val_i | input | 26 | Signed main value |
| add_val_i | input | 8 | Auxiliary value |
| err_flag_i | input | 1 | Measurement error flag |
| err_val_i | input | 26 | Substitute pattern used while in error |
| frame_o | output | 34 | Left-aligned frame word |
| frame_len_o | output | 6 | Number of valid bits in the frame |

## Verification
On every cycle, the assertions check several properties. The output holds between strobes. Each latched length is one of the six legal values. The bits below the length are zero. The parity sense matches the configuration, and the error bit carries the flag. The Gray encoder is checked against its own inverse. Only the bench scenarios show that the data bits carry the right value. That covers the two's complement and sign-magnitude forms, separate coding of the two parts, placement of the auxiliary byte, and substitution of the error pattern.

// File: rtl/ssi_fmt_pkg.sv
package ssi_fmt_pkg;
    localparam int VAL_W   = 26;
    localparam int ADD_W   = 8;
    localparam int MIN_LEN = 24;
    localparam int FRAME_W = VAL_W + ADD_W;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [LEN_W-1:0]   len;
    } fmt_state_t;
endpackage

// File: rtl/ssi_gray_enc.sv
module ssi_gray_enc #(
    parameter int W = 8
) (
    input  logic [W-1:0] bin_i,
    output logic [W-1:0] gray_o
);
    assign gray_o[W-1] = bin_i[W-1];
    for (genvar i = 0; i < W - 1; i++) begin : g_bit
        assign gray_o[i] = bin_i[i] ^ bin_i[i+1];
    end

    // a_r5_gray_inverse: decoding the code word must give back the input
    logic [W-1:0] dec_chk;
    always_comb begin
        dec_chk[W-1] = gray_o[W-1];
        for (int k = W - 2; k >= 0; k--) begin
            dec_chk[k] = dec_chk[k+1] ^ gray_o[k];
        end
        a_r5_gray_inverse: assert (dec_chk == bin_i);
    end
endmodule

// File: rtl/ssi_main_enc.sv
module ssi_main_enc #(
    parameter int VAL_W = ssi_fmt_pkg::VAL_W,
    parameter int CNT_W = $clog2(VAL_W + 1)
) (
    input  logic [VAL_W-1:0] val_i,
    input  logic [VAL_W-1:0] err_val_i,
    input  logic             err_flag_i,
    input  logic             sign_mag_i,
    input  logic             gray_en_i,
    input  logic [CNT_W-1:0] dbits_i,
    output logic [VAL_W-1:0] data_o
);
    localparam int EXT_W = VAL_W + 1;

    logic [EXT_W-1:0] mask_ext;
    logic [VAL_W-1:0] mask;
    logic [VAL_W-1:0] mag;
    logic [VAL_W-1:0] repr;
    logic [VAL_W-1:0] coded;
    logic             neg;

    always_comb begin
        mask_ext = (EXT_W'(1) << dbits_i) - EXT_W'(1);
        mask     = mask_ext[VAL_W-1:0];
        neg      = val_i[VAL_W-1];
        mag      = neg ? (~val_i + VAL_W'(1)) : val_i;
        if (sign_mag_i) begin
            repr = (mag & (mask >> 1)) | (neg ? (VAL_W'(1) << (dbits_i - CNT_W'(1))) : '0);
        end else begin
            repr = val_i & mask;
        end
    end

    ssi_gray_enc #(.W(VAL_W)) u_gray (
        .bin_i  (repr),
        .gray_o (coded)
    );

    always_comb begin
        if (err_flag_i) begin
            data_o = err_val_i & mask;
        end else if (gray_en_i) begin
            data_o = coded;
        end else begin
            data_o = repr;
        end
    end
endmodule

// File: rtl/ssi_frame_fmt.sv
module ssi_frame_fmt
    import ssi_fmt_pkg::*;
#(
    parameter int P_VAL_W = VAL_W,
    parameter int P_ADD_W = ADD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     latch_i,
    input  logic [1:0]               len_sel_i,
    input  logic                     gray_en_i,
    input  logic                     sign_mag_i,
    input  logic                     par_en_i,
    input  logic                     par_odd_i,
    input  logic                     err_bit_en_i,
    input  logic                     add_en_i,
    input  logic [P_VAL_W-1:0]       main_val_i,
    input  logic [P_ADD_W-1:0]       add_val_i,
    input  logic                     err_flag_i,
    input  logic [P_VAL_W-1:0]       err_val_i,
    output logic [FRAME_W-1:0]       frame_o,
    output logic [LEN_W-1:0]         frame_len_o
);
    localparam int CNT_W = $clog2(P_VAL_W + 1);

    fmt_state_t st_d, st_q;

    logic [LEN_W-1:0]   main_len;
    logic [CNT_W-1:0]   dbits;
    logic [P_VAL_W-1:0] data;
    logic [P_ADD_W-1:0] add_coded;
    logic [FRAME_W-1:0] word;
    logic               par_bit;

    always_comb begin
        main_len = (len_sel_i == 2'd3) ? LEN_W'(MIN_LEN + 2) : LEN_W'(MIN_LEN) + LEN_W'(len_sel_i);
        dbits    = CNT_W'(main_len) - CNT_W'(par_en_i) - CNT_W'(err_bit_en_i);
    end

    ssi_main_enc #(.VAL_W(P_VAL_W), .CNT_W(CNT_W)) u_main (
        .val_i      (main_val_i),
        .err_val_i  (err_val_i),
        .err_flag_i (err_flag_i),
        .sign_mag_i (sign_mag_i),
        .gray_en_i  (gray_en_i),
        .dbits_i    (dbits),
        .data_o     (data)
    );

    logic [P_ADD_W-1:0] add_gray;
    ssi_gray_enc #(.W(P_ADD_W)) u_add_gray (
        .bin_i  (add_val_i),
        .gray_o (add_gray)
    );
    assign add_coded = gray_en_i ? add_gray : add_val_i;

    always_comb begin
        word = FRAME_W'(data);
        if (err_bit_en_i) begin
            word = word | (FRAME_W'(err_flag_i) << dbits);
        end
        word = word << (LEN_W'(FRAME_W) - main_len);
        if (add_en_i) begin
            word = word | (FRAME_W'(add_coded) << (LEN_W'(FRAME_W - P_ADD_W) - main_len));
        end
        par_bit = (^word) ^ par_odd_i;
        if (par_en_i) begin
            word[FRAME_W-1] = par_bit;
        end

        st_d = st_q;
        if (latch_i) begin
            st_d.frame = word;
            st_d.len   = main_len + (add_en_i ? LEN_W'(P_ADD_W) : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_o     = st_q.frame;
    assign frame_len_o = st_q.len;

    a_r10_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_i |=> ($stable(frame_o) && $stable(frame_len_o)));

    a_r1_legal_length: assert property (@(posedge clk) disable iff (!rst_n)
        latch_i |=> (frame_len_o inside {6'd24, 6'd25, 6'd26, 6'd32, 6'd33, 6'd34}));

    a_r2_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_o << frame_len_o) == '0);

    a_r7_parity_sense: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && par_en_i) |=> ((^frame_o) == $past(par_odd_i)));

    a_r8_error_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && err_bit_en_i) |=>
            (frame_o[FRAME_W-1-int'($past(par_en_i))] == $past(err_flag_i)));
endmodule

// File: tb/ssi_frame_fmt_bench.sv
module ssi_frame_fmt_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        latch = 1'b0;
    logic [1:0]  len_sel = '0;
    logic        gray_en = 1'b0, sign_mag = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic        err_bit_en = 1'b0, add_en = 1'b0, err_flag = 1'b0;
    logic [25:0] main_val = '0, err_val = 26'h2AAAAAA;
    logic [7:0]  add_val = '0;
    logic [33:0] frame;
    logic [5:0]  flen;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ssi_frame_fmt u_ssi_frame_fmt (
        .clk(clk), .rst_n(rst_n), .latch_i(latch), .len_sel_i(len_sel),
        .gray_en_i(gray_en), .sign_mag_i(sign_mag), .par_en_i(par_en),
        .par_odd_i(par_odd), .err_bit_en_i(err_bit_en), .add_en_i(add_en),
        .main_val_i(main_val), .add_val_i(add_val), .err_flag_i(err_flag),
        .err_val_i(err_val), .frame_o(frame), .frame_len_o(flen)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic        gray, sm, par, odd, eb, add, errf;
        logic [25:0] mv;
        logic [7:0]  av;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0123456, 8'h00},
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 26'h3FFFFF0, 8'h00},
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 26'h1555555, 8'h00},
        '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 26'h0000005, 8'hC3},
        '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 26'h3FFFFFD, 8'h00},
        '{2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0000123, 8'h00},
        '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0ABCDEF, 8'h00},
        '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 26'h0F0F0F0, 8'hA5},
        '{2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0000007, 8'h00},
        '{2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 26'h0321321, 8'h81},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 26'h0000042, 8'h00},
        '{2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 26'h3FFFF00, 8'h5A},
        '{2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 26'h2000000, 8'hFF},
        '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 26'h3F00000, 8'h00}
    };

    function automatic int ref_len(vec_t v);
        int n = (v.sel == 2'd3) ? 26 : 24 + int'(v.sel);   // R1
        return n + (v.add ? 8 : 0);
    endfunction

    function automatic logic [33:0] ref_frame(vec_t v, logic [25:0] ev);
        int n = (v.sel == 2'd3) ? 26 : 24 + int'(v.sel);
        int d = n - int'(v.par) - int'(v.eb);
        logic [33:0] mask = (34'h1 << d) - 34'h1;
        logic [33:0] data, f;
        logic [25:0] mag;
        logic [7:0]  a;
        if (v.errf) begin
            data = {8'h0, ev} & mask;                       // R9
        end else begin
            if (v.sm) begin                                  // R4
                mag  = v.mv[25] ? -v.mv : v.mv;
                data = ({8'h0, mag} & (mask >> 1)) | (v.mv[25] ? (34'h1 << (d - 1)) : 34'h0);
            end else begin                                   // R3
                data = {{8{v.mv[25]}}, v.mv} & mask;
            end
            if (v.gray) data = data ^ (data >> 1);           // R5
        end
        if (v.eb) data = data | (34'(v.errf) << d);          // R8
        f = data << (34 - n);                                // R2
        if (v.add) begin                                     // R6
            a = v.gray ? (v.av ^ (v.av >> 1)) : v.av;
            f = f | (34'(a) << (34 - n - 8));
        end
        if (v.par) f[33] = (^f) ^ v.odd;                     // R7
        return f;
    endfunction

    function automatic string tag_of(vec_t v);
        if (v.errf) return "R9";
        if (v.par)  return "R7";
        if (v.eb)   return "R8";
        if (v.add)  return "R6";
        if (v.gray) return "R5";
        if (v.sm)   return "R4";
        return "R3";
    endfunction

    task automatic check(string tag, logic [33:0] act, logic [33:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(vec_t v);
        len_sel = v.sel; gray_en = v.gray; sign_mag = v.sm; par_en = v.par;
        par_odd = v.odd; err_bit_en = v.eb; add_en = v.add; err_flag = v.errf;
        main_val = v.mv; add_val = v.av;
    endtask

    task automatic apply(vec_t v);
        @(negedge clk);
        drive(v);
        latch = 1'b1;
        @(negedge clk);
        latch = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        vec_t v;
        logic [33:0] held_f;
        logic [5:0]  held_l;
        repeat (3) @(negedge clk);
        check("R10 reset frame", frame, 34'h0);
        check("R10 reset len", 34'(flen), 34'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            check(tag_of(VEC[i]), frame, ref_frame(VEC[i], err_val));
            check("R1 length", 34'(flen), 34'(ref_len(VEC[i])));
        end

        // R2 directed: value 1 in a 24-bit frame lands at bit 10
        v = '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0000001, 8'h00};
        apply(v);
        check("R2 left aligned", frame, 34'h000000400);
        // R3 directed: minus one fills the top 24 bits
        v.mv = 26'h3FFFFFF;
        apply(v);
        check("R3 minus one", frame, 34'h3FFFFFC00);

        // R10: change every input without a strobe, output must hold
        held_f = frame;
        held_l = flen;
        @(negedge clk);
        drive('{2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 26'h1234567, 8'h77});
        repeat (2) @(negedge clk);
        check("R10 hold frame", frame, held_f);
        check("R10 hold len", 34'(flen), 34'(held_l));

        // R10: reset in mid-run clears the output
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 second reset", frame, 34'h0);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule